// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides an input clock by an integer N using a coarse prescaler that divides by either P or P+1, followed by a swallow counter (A) and a main counter (B). During each output period the prescaler divides by P+1 until the swallow counter runs out, and then divides by P for the rest of the main count. When the main counter expires, both counters reload and the block emits one divided pulse. The resulting period is N = B·P + A input cycles. A is kept below P, so every integer N from P²−P upward can be reached with a prescaler that only knows two ratios.

Software or a sequencer presents P, A and B and pulses a load strobe. The block checks the values at that point. A valid set is held aside and takes effect at the next period boundary, so the period in progress is never disturbed. An invalid set raises an error flag and is discarded, and the divider keeps running on its last good values. All logic runs on the input clock. The modulus-control output shows which ratio the prescaler is using in each cycle.

Top module: `dmod_divider`

## Requirements
- R1: With a valid configuration (P, A, B), consecutive `div_pulse` assertions are exactly B·P + A input cycles apart.
- R2: `mod_ctrl` is 1 (prescaler dividing by P+1) for the first A·(P+1) input cycles of each period and 0 for the remaining (B−A)·P cycles. It can only rise at a period boundary.
- R3: `div_pulse` is one input clock wide. It is high during the first cycle of each new period, which is the cycle after the main counter expires.
- R4: Values captured by `load` take effect only at the next period boundary. The period in progress keeps its old length.
- R5: A load is rejected when P < 2, A ≥ P, B < A or B = 0. In that case `cfg_err` becomes 1 on the next cycle and the running and pending configuration are unchanged. A later valid load clears `cfg_err` on the next cycle.
- R6: While `rst` is high the counters take the values on `div_p`/`div_a`/`div_b`, `div_pulse` is 0, and `mod_ctrl` equals (A > 0). The first pulse is seen N cycles after reset is released. If those inputs are invalid, the defaults (P=4, A=1, B=3, N=13) are used and `cfg_err` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for `div_p`, `div_a`, `div_b` |
| div_p | input | P_W (6) | Prescaler base ratio P |
| div_a | input | A_W (6) | Swallow count A |
| div_b | input | B_W (13) | Main count B |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| mod_ctrl | output | 1 | 1 = prescaler divides by P+1, 0 = by P |
| cfg_err | output | 1 | Last load (or reset value) was rejected |

## Verification
A table of configurations is applied one after another. It covers A = 0 (a pure P division with no P+1 phase), A = B (P+1 for the whole period), the smallest legal N of 2, a small P with a large B, and the 32/33 extremes at N = 992 and N = 1023. Counting both the period and the high time of the modulus control separates a wrong total from a correct total split wrongly between the two ratios. Directed runs then load a new set part way through a period, so that a wrongly applied early update would shorten the current period. They also apply each class of illegal value and check that the period stays the same, and they reset with both legal and illegal inputs to check the start-up count and the initial modulus.

// File: rtl/dmod_pkg.sv
package dmod_pkg;
  // Prescaler ratio selector for the upcoming prescaler cycle.
  typedef enum logic {
    DIV_P  = 1'b0,
    DIV_P1 = 1'b1
  } modsel_e;
endpackage

// File: rtl/dmod_cfg.sv
module dmod_cfg #(
  parameter int P_W   = 6,
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int DEF_P = 4,
  parameter int DEF_A = 1,
  parameter int DEF_B = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic [P_W-1:0] p_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic           bound_i,
  output logic [P_W-1:0] act_p_o,
  output logic [P_W-1:0] ld_p_o,
  output logic [A_W-1:0] ld_a_o,
  output logic [B_W-1:0] ld_b_o,
  output logic           err_o
);
  localparam int CW0 = (A_W > P_W) ? A_W : P_W;
  localparam int CW  = (B_W > CW0) ? B_W : CW0;

  logic [CW-1:0]  px, ax, bx;
  logic           in_ok;
  logic [P_W-1:0] boot_p, act_p, pend_p;
  logic [A_W-1:0] boot_a, act_a, pend_a;
  logic [B_W-1:0] boot_b, act_b, pend_b;
  logic           pend_vld, err_q;

  assign px    = CW'(p_i);
  assign ax    = CW'(a_i);
  assign bx    = CW'(b_i);
  assign in_ok = (px >= CW'(2)) && (ax < px) && (bx >= ax) && (bx != '0);

  always_comb begin
    if (in_ok) begin
      boot_p = p_i; boot_a = a_i; boot_b = b_i;
    end else begin
      boot_p = P_W'(DEF_P); boot_a = A_W'(DEF_A); boot_b = B_W'(DEF_B);
    end
  end

  always_comb begin
    if (rst) begin
      ld_p_o = boot_p; ld_a_o = boot_a; ld_b_o = boot_b;
    end else if (pend_vld) begin
      ld_p_o = pend_p; ld_a_o = pend_a; ld_b_o = pend_b;
    end else begin
      ld_p_o = act_p;  ld_a_o = act_a;  ld_b_o = act_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_p    <= boot_p; act_a  <= boot_a; act_b  <= boot_b;
      pend_p   <= boot_p; pend_a <= boot_a; pend_b <= boot_b;
      pend_vld <= 1'b0;
      err_q    <= !in_ok;
    end else begin
      if (bound_i) begin
        act_p    <= ld_p_o;
        act_a    <= ld_a_o;
        act_b    <= ld_b_o;
        pend_vld <= 1'b0;
      end
      if (load_i) begin
        if (in_ok) begin
          pend_p   <= p_i;
          pend_a   <= a_i;
          pend_b   <= b_i;
          pend_vld <= 1'b1;
          err_q    <= 1'b0;
        end else begin
          err_q <= 1'b1;
        end
      end
    end
  end

  assign act_p_o = act_p;
  assign err_o   = err_q;

  AST_BAD_LOAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (load_i && !in_ok) |=> (err_q && $stable(pend_p) && $stable(pend_a) && $stable(pend_b))); // R5
  AST_GOOD_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (load_i && in_ok) |=> (!err_q && pend_vld)); // R5
  AST_ACTIVE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (CW'(act_a) < CW'(act_p)) && (CW'(act_b) >= CW'(act_a)) && (act_b != '0)); // R5
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
  import dmod_pkg::*;
#(
  parameter int P_W = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] p_i,
  input  modsel_e        sel_i,
  output logic           end_o
);
  logic [P_W-1:0] cnt;

  assign end_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || end_o) begin
      cnt <= (sel_i == DIV_P1) ? p_i : (p_i - P_W'(1));
    end else begin
      cnt <= cnt - P_W'(1);
    end
  end

  AST_PS_WITHIN_RATIO: assert property (@(posedge clk) disable iff (rst)
    cnt <= p_i); // R1
endmodule

// File: rtl/dmod_swallow.sv
module dmod_swallow
  import dmod_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic [A_W-1:0] ld_a_i,
  input  logic [B_W-1:0] ld_b_i,
  output logic           timeout_o,
  output modsel_e        sel_next_o,
  output logic           mod_o,
  output logic           pulse_o
);
  logic [A_W-1:0] a_rem, a_nxt;
  logic [B_W-1:0] b_rem, b_nxt;
  logic           reload, mod_q, pulse_q;

  assign timeout_o = tick_i && (b_rem == B_W'(1));
  assign reload    = rst || timeout_o;

  always_comb begin
    a_nxt = a_rem;
    b_nxt = b_rem;
    if (reload) begin
      a_nxt = ld_a_i;
      b_nxt = ld_b_i;
    end else if (tick_i) begin
      if (a_rem != '0) a_nxt = a_rem - A_W'(1);
      b_nxt = b_rem - B_W'(1);
    end
  end

  assign sel_next_o = (a_nxt != '0) ? DIV_P1 : DIV_P;

  always_ff @(posedge clk) begin
    a_rem   <= a_nxt;
    b_rem   <= b_nxt;
    mod_q   <= (a_nxt != '0);
    pulse_q <= !rst && timeout_o;
  end

  assign mod_o   = mod_q;
  assign pulse_o = pulse_q;

  AST_SWALLOW_NOT_ABOVE_MAIN: assert property (@(posedge clk) disable iff (rst)
    B_W'(a_rem) <= b_rem); // R1
  AST_MAIN_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    b_rem != '0); // R1
  AST_MOD_RISES_AT_BOUND: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_q) |-> $past(timeout_o)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R3
endmodule

// File: rtl/dmod_divider.sv
module dmod_divider
  import dmod_pkg::*;
#(
  parameter int P_W   = 6,
  parameter int A_W   = 6,
  parameter int B_W   = 13,
  parameter int DEF_P = 4,
  parameter int DEF_A = 1,
  parameter int DEF_B = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [P_W-1:0] div_p,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  output logic           div_pulse,
  output logic           mod_ctrl,
  output logic           cfg_err
);
  logic [P_W-1:0] act_p, ld_p, ps_p;
  logic [A_W-1:0] ld_a;
  logic [B_W-1:0] ld_b;
  logic           ps_end, timeout;
  modsel_e        sel_next;

  dmod_cfg #(
    .P_W(P_W), .A_W(A_W), .B_W(B_W),
    .DEF_P(DEF_P), .DEF_A(DEF_A), .DEF_B(DEF_B)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .p_i     (div_p),
    .a_i     (div_a),
    .b_i     (div_b),
    .bound_i (timeout),
    .act_p_o (act_p),
    .ld_p_o  (ld_p),
    .ld_a_o  (ld_a),
    .ld_b_o  (ld_b),
    .err_o   (cfg_err)
  );

  // A period boundary reloads the prescaler with the new ratio base.
  assign ps_p = (rst || timeout) ? ld_p : act_p;

  dmod_prescaler #(.P_W(P_W)) u_ps (
    .clk   (clk),
    .rst   (rst),
    .p_i   (ps_p),
    .sel_i (sel_next),
    .end_o (ps_end)
  );

  dmod_swallow #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (ps_end),
    .ld_a_i     (ld_a),
    .ld_b_i     (ld_b),
    .timeout_o  (timeout),
    .sel_next_o (sel_next),
    .mod_o      (mod_ctrl),
    .pulse_o    (div_pulse)
  );

  AST_PULSE_MEANS_BOUND: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> $past(timeout)); // R3
endmodule

// File: tb/tb_dmod_divider.sv
`timescale 1ns/1ps
module tb_dmod_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [5:0]  div_p = 6'd4;
  logic [5:0]  div_a = 6'd1;
  logic [12:0] div_b = 13'd3;
  logic        div_pulse, mod_ctrl, cfg_err;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmod_divider dut (
    .clk(clk), .rst(rst), .load(load),
    .div_p(div_p), .div_a(div_a), .div_b(div_b),
    .div_pulse(div_pulse), .mod_ctrl(mod_ctrl), .cfg_err(cfg_err)
  );

  // {P, A, B}
  localparam int NV = 10;
  localparam int VEC [NV][3] = '{
    '{4, 1, 3}, '{4, 0, 3}, '{4, 3, 3}, '{2, 1, 1}, '{2, 0, 1},
    '{8, 7, 9}, '{5, 2, 6}, '{32, 0, 31}, '{32, 31, 31}, '{3, 0, 5}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input int a, input int b);
    div_p = 6'(p);
    div_a = 6'(a);
    div_b = 13'(b);
  endtask

  task automatic wait_pulse();
    int g = 0;
    do begin
      @(negedge clk);
      load = 1'b0;
      g++;
    end while (!div_pulse && g < 5000);
  endtask

  // Starts on a sample where div_pulse is high; counts to the next pulse.
  task automatic measure(output int per, output int modhi, output int second);
    per = 0; modhi = 0; second = 1;
    do begin
      modhi += int'(mod_ctrl);
      per++;
      @(negedge clk);
      load = 1'b0;
      if (per == 1) second = int'(div_pulse);
    end while (!div_pulse && per < 5000);
  endtask

  task automatic do_reset(input int p, input int a, input int b);
    drive(p, a, b);
    rst = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int per, mh, sec, k;
    // R6: reset with legal inputs
    do_reset(4, 1, 3);
    chk("R6 pulse low in reset", int'(div_pulse), 0);
    chk("R6 mod_ctrl=A>0 in reset", int'(mod_ctrl), 1);
    chk("R6 cfg_err clear", int'(cfg_err), 0);
    rst = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!div_pulse && k < 5000);
    chk("R6 first pulse after N", k, 13);

    // R6: reset with A=0 gives P-only start
    do_reset(5, 0, 2);
    chk("R6 mod_ctrl low when A=0", int'(mod_ctrl), 0);
    rst = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!div_pulse && k < 5000);
    chk("R6 first pulse A=0", k, 10);

    // R1/R2/R3: table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][0], VEC[i][1], VEC[i][2]);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      wait_pulse();
      measure(per, mh, sec);
      chk($sformatf("R1 period vec%0d", i), per, VEC[i][2]*VEC[i][0] + VEC[i][1]);
      chk($sformatf("R2 P+1 time vec%0d", i), mh, VEC[i][1]*(VEC[i][0]+1));
      chk($sformatf("R3 pulse width vec%0d", i), sec, 0);
    end

    // R4: load mid-period; current period keeps old length (3,0,5 -> 15)
    measure(per, mh, sec);
    drive(4, 2, 4);
    load = 1'b1;
    measure(per, mh, sec);
    chk("R4 current period unchanged", per, 15);
    measure(per, mh, sec);
    chk("R4 new period after boundary", per, 18);

    // R5: illegal loads rejected, period stays 18
    drive(4, 4, 5);           // A >= P
    load = 1'b1;
    measure(per, mh, sec);
    chk("R5 err on A>=P", int'(cfg_err), 1);
    measure(per, mh, sec);
    chk("R5 A>=P ignored", per, 18);
    drive(8, 5, 3);           // B < A
    load = 1'b1;
    measure(per, mh, sec);
    measure(per, mh, sec);
    chk("R5 B<A ignored", per, 18);
    chk("R5 err on B<A", int'(cfg_err), 1);
    drive(1, 0, 4);           // P < 2
    load = 1'b1;
    measure(per, mh, sec);
    measure(per, mh, sec);
    chk("R5 P<2 ignored", per, 18);
    drive(4, 0, 0);           // B = 0
    load = 1'b1;
    measure(per, mh, sec);
    measure(per, mh, sec);
    chk("R5 B=0 ignored", per, 18);
    chk("R5 P+1 time kept", mh, 10);
    drive(6, 1, 2);           // valid clears error
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R5 valid load clears err", int'(cfg_err), 0);
    wait_pulse();
    measure(per, mh, sec);
    chk("R5 valid load applied", per, 13);

    // R6: reset with illegal inputs uses defaults
    do_reset(4, 4, 5);
    chk("R6 err on bad reset values", int'(cfg_err), 1);
    rst = 1'b0;
    k = 0;
    do begin @(negedge clk); k++; end while (!div_pulse && k < 5000);
    chk("R6 default period", k, 13);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule